// File: doc/BRIEF.md
# Port-Sized Cache Fill Responder

This block is the slave end of a read cycle on a 32-bit processor bus that sizes each transfer to the port that answers it. The port width is fixed when the block is built: 8, 16 or 32 bits. A cachable read always gets a full port-width item, whatever operand size the processor asked for. The item is placed on the upper byte lanes of the data bus, and the block ends the cycle with a two-bit acknowledge that tells the processor the port width.

Each accepted read ends after a wait count set by a parameter. A four-entry table chooses whether a read is marked not cacheable, and the entry is picked by the top two address bits. One address window, set by a base and a mask, stands for a device that fails. A read in that window ends with an error and no data acknowledge. It is also marked not cacheable. Data is taken from a built-in address pattern, so no backing storage is needed.

Top module: `fill_responder`

## Requirements
- R1: After reset, and whenever no read is being terminated, `ack_vld`, `berr` and `cinh` are 0, `rdata` is all zeros and `ack_size` is 2'b11.
- R2: A read accepted at clock edge k is terminated during the single cycle that follows edge k+1+WAIT_CYC. The termination signals are high for exactly that one cycle.
- R3: With PORT_W=32, `rdata` holds the four bytes of the aligned long word that contains the address. The byte at the lowest address is on bits 31:24 and the byte at the highest address is on bits 7:0.
- R4: With PORT_W=16, bits 31:16 hold the aligned word: the even-address byte on 31:24 and the odd-address byte on 23:16. Bits 15:0 are zero.
- R5: With PORT_W=8, bits 31:24 hold the addressed byte and bits 23:0 are zero.
- R6: Neither `size_code` nor the address bits below the port alignment have any effect on `rdata`.
- R7: When `ack_vld` is high, `ack_size` is 2'b00 for a 32-bit port, 2'b01 for a 16-bit port and 2'b10 for an 8-bit port.
- R8: `cinh` is high during the termination cycle exactly when bit `addr[31:30]` of INHIBIT_MAP is set, or when the address faults.
- R9: An address with (addr & FAULT_MASK) == FAULT_BASE terminates with `berr`=1, `ack_vld`=0, `cinh`=1 and `rdata` zero.
- R10: `rd_req` is ignored while a read is in progress. No second termination follows, and the data still belongs to the first address.
- R11: The byte held at address a is ((a[7:0] xor a[15:8]) + 8'h3C) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read strobe, sampled when idle |
| addr | input | 32 | Byte address of the read |
| size_code | input | 2 | Requested operand size (ignored) |
| rdata | output | 32 | Returned data, upper lanes used |
| ack_vld | output | 1 | Normal termination strobe |
| ack_size | output | 2 | Port-size acknowledge code |
| cinh | output | 1 | Cache inhibit for this read |
| berr | output | 1 | Error termination |

## Verification
The hardest case to reach from the ports is a second strobe that arrives while the first read is still waiting. It can only be produced by timing `rd_req` against each instance's wait count. The bench raises the strobe again, with a different address, two cycles after the first request. At that moment all three instances are still busy: wait counts 0, 1 and 2 put them in their termination or wait states. The bench then checks that each instance terminates exactly once, with the first address's data. Three instances, one per port width, share the same stimulus, so each address is checked under every lane layout.

// File: rtl/fill_pkg.sv
package fill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TERM = 2'd2
  } fill_state_t;

  localparam logic [1:0] ACK_NONE = 2'b11;

  // Pattern byte held at a byte address.
  function automatic logic [7:0] pattern_byte(input logic [31:0] a);
    return (a[7:0] ^ a[15:8]) + 8'h3C;
  endfunction

  // Size acknowledge code for a port width.
  function automatic logic [1:0] port_code(input int unsigned width);
    if (width == 32) return 2'b00;
    else if (width == 16) return 2'b01;
    else return 2'b10;
  endfunction

endpackage

// File: rtl/fill_region_map.sv
module fill_region_map #(
  parameter logic [3:0]  INHIBIT_MAP = 4'b0100,
  parameter logic [31:0] FAULT_BASE  = 32'h0BAD_0000,
  parameter logic [31:0] FAULT_MASK  = 32'hFFFF_F000
) (
  input  logic [31:0] addr,
  output logic        region_inhibit,
  output logic        region_fault
);
  logic [1:0] region_idx;

  assign region_idx     = addr[31:30];
  assign region_inhibit = INHIBIT_MAP[region_idx];
  assign region_fault   = ((addr & FAULT_MASK) == FAULT_BASE);
endmodule

// File: rtl/fill_wait_timer.sv
module fill_wait_timer
  import fill_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic term
);
  localparam int unsigned CW = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC);

  fill_state_t   state;
  logic [CW-1:0] cnt;
  logic          wait_done;

  assign accept    = (state == ST_IDLE) && start;
  assign wait_done = (cnt == LAST);
  assign term      = (state == ST_TERM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_WAIT;
          cnt   <= '0;
        end
        ST_WAIT: begin
          if (wait_done) state <= ST_TERM;
          else           cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  term_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> !term);

  // R10
  wait_from_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == ST_WAIT) && (cnt == '0));
endmodule

// File: rtl/fill_lane_packer.sv
module fill_lane_packer
  import fill_pkg::*;
#(
  parameter int unsigned PORT_W = 32
) (
  input  logic [31:0] addr,
  output logic [31:0] word
);
  localparam int unsigned NBYTES = PORT_W / 8;

  generate
    if (PORT_W == 32) begin : g_long
      logic [31:0] base;
      assign base = {addr[31:2], 2'b00};
      for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign word[31-8*i -: 8] = pattern_byte(base + 32'(i));
      end
    end else if (PORT_W == 16) begin : g_word
      logic [31:0] base;
      assign base = {addr[31:1], 1'b0};
      for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign word[31-8*i -: 8] = pattern_byte(base + 32'(i));
      end
      assign word[15:0] = '0;
    end else begin : g_byte
      assign word[31:24] = pattern_byte(addr);
      assign word[23:0]  = '0;
    end
  endgenerate
endmodule

// File: rtl/fill_responder.sv
module fill_responder
  import fill_pkg::*;
#(
  parameter int unsigned PORT_W      = 32,
  parameter int unsigned WAIT_CYC    = 2,
  parameter logic [3:0]  INHIBIT_MAP = 4'b0100,
  parameter logic [31:0] FAULT_BASE  = 32'h0BAD_0000,
  parameter logic [31:0] FAULT_MASK  = 32'hFFFF_F000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic [31:0] addr,
  input  logic [1:0]  size_code,
  output logic [31:0] rdata,
  output logic        ack_vld,
  output logic [1:0]  ack_size,
  output logic        cinh,
  output logic        berr
);
  localparam logic [1:0] MY_CODE = port_code(PORT_W);

  logic        accept, term;
  logic [31:0] addr_q;
  logic        rgn_inh, rgn_flt;
  logic [31:0] packed_word;
  logic        unused_size;

  assign unused_size = ^size_code;

  fill_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(rd_req), .accept(accept), .term(term)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= addr;
  end

  fill_region_map #(
    .INHIBIT_MAP(INHIBIT_MAP), .FAULT_BASE(FAULT_BASE), .FAULT_MASK(FAULT_MASK)
  ) u_map (
    .addr(addr_q), .region_inhibit(rgn_inh), .region_fault(rgn_flt)
  );

  fill_lane_packer #(.PORT_W(PORT_W)) u_pack (
    .addr(addr_q), .word(packed_word)
  );

  assign ack_vld  = term && !rgn_flt;
  assign berr     = term && rgn_flt;
  assign cinh     = term && (rgn_inh || rgn_flt);
  assign rdata    = ack_vld ? packed_word : '0;
  assign ack_size = ack_vld ? MY_CODE : ACK_NONE;

  // R9
  ack_berr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_vld && berr));

  // R9
  berr_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    berr |-> cinh && (rdata == '0));

  // R8
  cinh_in_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cinh |-> (ack_vld || berr));

  // R7
  ack_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> (ack_size != ACK_NONE));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_vld || berr) |-> (ack_size == ACK_NONE) && (rdata == '0) && !cinh);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && $past(rst_n)) |=> $stable(addr_q));
endmodule

// File: tb/tb_fill_responder.sv
module tb_fill_responder;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 3;

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  sz;
    logic        flt;
    logic        inh;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1237, 2'd0, 1'b0, 1'b0},
    '{32'h0000_1234, 2'd3, 1'b0, 1'b0},
    '{32'h0000_1235, 2'd2, 1'b0, 1'b0},
    '{32'h4000_00FE, 2'd1, 1'b0, 1'b0},
    '{32'h8000_0010, 2'd2, 1'b0, 1'b1},
    '{32'hBFFF_FFFD, 2'd0, 1'b0, 1'b1},
    '{32'hC123_4561, 2'd0, 1'b0, 1'b0},
    '{32'h0BAD_0004, 2'd1, 1'b1, 1'b1},
    '{32'hFFFF_FFFF, 2'd1, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0, rd_req = 0;
  logic [31:0] addr = '0;
  logic [1:0]  size_code = '0;
  int total = 0, bad = 0;

  logic [31:0] rd  [ND];
  logic        ak  [ND];
  logic [1:0]  asz [ND];
  logic        ci  [ND];
  logic        be  [ND];

  always #(CLK_PERIOD/2) clk = ~clk;

  fill_responder #(.PORT_W(32), .WAIT_CYC(2)) dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .addr(addr), .size_code(size_code),
    .rdata(rd[0]), .ack_vld(ak[0]), .ack_size(asz[0]), .cinh(ci[0]), .berr(be[0]));
  fill_responder #(.PORT_W(16), .WAIT_CYC(1)) dut16 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .addr(addr), .size_code(size_code),
    .rdata(rd[1]), .ack_vld(ak[1]), .ack_size(asz[1]), .cinh(ci[1]), .berr(be[1]));
  fill_responder #(.PORT_W(8), .WAIT_CYC(0)) dut8 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .addr(addr), .size_code(size_code),
    .rdata(rd[2]), .ack_vld(ak[2]), .ack_size(asz[2]), .cinh(ci[2]), .berr(be[2]));

  function automatic int pw_of(int d);
    return (d == 0) ? 32 : (d == 1) ? 16 : 8;
  endfunction
  function automatic int wt_of(int d);
    return 2 - d;
  endfunction

  // R11 restated: byte value from address arithmetic
  function automatic logic [7:0] bval(logic [31:0] a);
    int v;
    v = ((a % 256) ^ ((a / 256) % 256)) + 60;
    return 8'(v % 256);
  endfunction

  function automatic logic [31:0] exp_word(int pw, logic [31:0] a);
    logic [31:0] b;
    if (pw == 32) begin
      b = a - (a % 4);
      return {bval(b), bval(b + 1), bval(b + 2), bval(b + 3)};
    end else if (pw == 16) begin
      b = a - (a % 2);
      return {bval(b), bval(b + 1), 16'h0000};
    end
    return {bval(a), 24'h000000};
  endfunction

  function automatic logic [1:0] exp_code(int pw);
    return (pw == 32) ? 2'b00 : (pw == 16) ? 2'b01 : 2'b10;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(string req);
    for (int d = 0; d < ND; d++) begin
      check(!ak[d] && !be[d] && !ci[d] && rd[d] == 0 && asz[d] == 2'b11, req,
            $sformatf("idle outputs dut%0d", d),
            {ak[d], be[d], ci[d], asz[d], rd[d][26:0]}, {3'b000, 2'b11, 27'd0});
    end
  endtask

  task automatic do_read(logic [31:0] a, logic [1:0] sz, bit flt, bit inh, bit poke);
    int hits [ND];
    int at_n [ND];
    logic [31:0] cd [ND];
    logic [1:0]  cs [ND];
    logic        ca [ND], cc [ND], cb [ND];
    for (int d = 0; d < ND; d++) begin
      hits[d] = 0; at_n[d] = 0; cd[d] = '0; cs[d] = '0; ca[d] = 0; cc[d] = 0; cb[d] = 0;
    end
    @(negedge clk);
    addr = a; size_code = sz; rd_req = 1;
    for (int n = 1; n <= 8; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 1) begin
        rd_req = 0;
        addr = ~a; size_code = ~sz;
      end
      if (poke && n == 2) begin
        rd_req = 1;
        addr = 32'h8000_0000;
      end
      if (poke && n == 3) rd_req = 0;
      for (int d = 0; d < ND; d++) begin
        if (ak[d] || be[d]) begin
          hits[d]++;
          at_n[d] = n;
          cd[d] = rd[d]; cs[d] = asz[d]; ca[d] = ak[d]; cc[d] = ci[d]; cb[d] = be[d];
        end
      end
    end
    for (int d = 0; d < ND; d++) begin
      int pw;
      pw = pw_of(d);
      // R2 / R10: exactly one termination, at WAIT_CYC+2 edges counting the accept edge
      check(hits[d] == 1, poke ? "R10" : "R2", $sformatf("termination count dut%0d", d),
            32'(hits[d]), 32'd1);
      check(at_n[d] == wt_of(d) + 2, "R2", $sformatf("termination cycle dut%0d", d),
            32'(at_n[d]), 32'(wt_of(d) + 2));
      // R8
      check(cc[d] == inh, "R8", $sformatf("cinh dut%0d", d), 32'(cc[d]), 32'(inh));
      if (flt) begin
        // R9
        check(cb[d] && !ca[d] && cd[d] == 0, "R9", $sformatf("fault termination dut%0d", d),
              {cb[d], ca[d], cd[d][29:0]}, {1'b1, 31'd0});
      end else begin
        // R3 R4 R5 R6 R11
        check(cd[d] == exp_word(pw, a), pw == 32 ? "R3" : pw == 16 ? "R4" : "R5",
              $sformatf("lanes dut%0d", d), cd[d], exp_word(pw, a));
        // R7
        check(ca[d] && !cb[d] && cs[d] == exp_code(pw), "R7", $sformatf("ack code dut%0d", d),
              32'(cs[d]), 32'(exp_code(pw)));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rd_req = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_req = 0;
    rst_n = 1;
    // R1 reset state
    check_idle("R1");

    // table walk
    for (int i = 0; i < NV; i++) begin
      do_read(VECS[i].a, VECS[i].sz, VECS[i].flt, VECS[i].inh, 1'b0);
    end

    // R6: same long word, different low bits and size codes
    do_read(32'h0000_5670, 2'd0, 1'b0, 1'b0, 1'b0);
    do_read(32'h0000_5673, 2'd3, 1'b0, 1'b0, 1'b0);

    // R10: strobe again while busy
    do_read(32'h4000_1002, 2'd2, 1'b0, 1'b0, 1'b1);

    // R1 quiet after activity
    repeat (2) @(negedge clk);
    check_idle("R1");

    // R1 reset in the middle of a read
    @(negedge clk);
    addr = 32'h0000_0040; rd_req = 1;
    @(negedge clk);
    rd_req = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    check_idle("R1");
    rst_n = 1;
    repeat (5) @(negedge clk);
    check_idle("R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule